// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block is a tiny physically addressed data cache between a load/store unit and a line-wide memory port. The CPU side issues one access at a time: a 7-bit byte address, a read/write flag, a byte count of one to four, and write data. Each accepted access produces a one-cycle response pulse. The pulse carries hit status, an error flag, and read data in little-endian order. Storage is 8 sets of 2 ways, each way holding one 4-byte line. Each line has a tag, a valid bit and a dirty bit, and each set has one least-recently-used bit.

A hit is served from the arrays and answered in the following cycle. A miss raises `busy` and hands control to a four-state controller. From `ST_IDLE` the controller moves to `ST_EVICT` when the chosen victim is valid and dirty, and otherwise to `ST_FETCH`. `ST_EVICT` leaves for `ST_FETCH` once the write-back is accepted. `ST_FETCH` leaves for `ST_WAIT` once the line read is accepted. `ST_WAIT` returns to `ST_IDLE` when the fill data arrives. On that edge the line is installed, write data is merged into it, and the response is issued. Memory transfers always move a whole line, using a valid/ready request channel and a separate response strobe.

Top module: `dcache2w`

## Requirements
- R1: The address splits, from most to least significant, into tag a[6:5], set index a[4:2] and byte offset a[1:0]. Every memory request carries the 5-bit line address {tag, index}.
- R2: A read returns the byte at the lowest address in resp_rdata[7:0] and the following bytes in ascending byte lanes. Lanes above the access size read as zero. req_size encodes the byte count minus one.
- R3: A write changes exactly the addressed bytes. Byte k of the access takes req_wdata[8k+7:8k], and every other byte of the line keeps its value.
- R4: An access that hits produces resp_valid with resp_hit=1 in the cycle after acceptance, and busy stays low.
- R5: A miss raises busy from the cycle after acceptance. busy stays high until the fill completes. resp_valid then pulses with resp_hit=0 in the first cycle busy is low again.
- R6: On a miss, an invalid way is chosen (way 0 before way 1). If both ways are valid, the way not used most recently in that set is chosen. Every hit and every fill marks the touched way as most recent.
- R7: A valid dirty victim is written to memory as a whole line at the victim's line address before the new line is requested. Memory request fields hold steady while the request is not accepted. A clean victim is not written back.
- R8: A write miss fetches the line, merges the write data, and leaves the line dirty. A read fill leaves it clean. Only a valid line can be dirty.
- R9: An access where offset + byte count exceeds 4 produces resp_err with resp_valid in the next cycle. It makes no memory request and changes no cache state.
- R10: Reset clears all valid, dirty and LRU bits, so the first access to any line after reset misses.
- R11: Requests presented while busy is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request, taken when busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Byte address |
| req_size | input | 2 | Byte count minus one |
| req_wdata | input | 32 | Write bytes, lowest address in bits 7:0 |
| busy | output | 1 | Miss in progress |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_hit | output | 1 | Access was served without a fill |
| resp_err | output | 1 | Access crossed the line end |
| resp_rdata | output | 32 | Little-endian read data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = line write-back, 0 = line read |
| mem_req_addr | output | 5 | Line address {tag, index} |
| mem_req_wdata | output | 32 | Line written back |
| mem_rsp_valid | input | 1 | Fill data valid |
| mem_rsp_data | input | 32 | Fill line data |

## Verification
Hits and line-crossing errors are due exactly one cycle after the accepting edge. The bench drives on the falling edge and samples at the next falling edge, so it checks the registered response and the low busy level together. For a miss, busy must already be high at that first sample. The bench then counts falling edges until the response pulse and requires busy to be low in that same sample. Fill and write-back counts from the bench's memory model are compared after each access with counts predicted by an arithmetic tag/LRU model.

// File: rtl/dc_pkg.sv
package dc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVICT = 2'd1,
        ST_FETCH = 2'd2,
        ST_WAIT  = 2'd3
    } dc_state_e;

endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
    parameter int SETS  = 8,
    parameter int TAG_W = 2,
    parameter int IDX_W = $clog2(SETS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [1:0][TAG_W-1:0]  rd_tag,
    output logic [1:0]             rd_valid,
    output logic [1:0]             rd_dirty,
    output logic                   rd_lru,
    input  logic                   wr_en,
    input  logic                   wr_way,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [TAG_W-1:0]       wr_tag,
    input  logic                   wr_dirty,
    input  logic                   lru_en,
    input  logic [IDX_W-1:0]       lru_idx,
    input  logic                   lru_used
);

    logic [TAG_W-1:0]       tag_q [SETS][2];
    logic [SETS-1:0][1:0]   valid_q;
    logic [SETS-1:0][1:0]   dirty_q;
    logic [SETS-1:0]        lru_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx][wr_way] <= wr_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
            lru_q   <= '0;
        end else begin
            if (wr_en) begin
                valid_q[wr_idx][wr_way] <= 1'b1;
                dirty_q[wr_idx][wr_way] <= wr_dirty;
            end
            if (lru_en) begin
                lru_q[lru_idx] <= ~lru_used;
            end
        end
    end

    always_comb begin
        rd_tag[0] = tag_q[rd_idx][0];
        rd_tag[1] = tag_q[rd_idx][1];
        rd_valid  = valid_q[rd_idx];
        rd_dirty  = dirty_q[rd_idx];
        rd_lru    = lru_q[rd_idx];
    end

    for (genvar s = 0; s < SETS; s++) begin : g_chk
        for (genvar w = 0; w < 2; w++) begin : g_way
            AST_DIRTY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
                dirty_q[s][w] |-> valid_q[s][w]); // R8
        end
    end

endmodule

// File: rtl/dc_data_store.sv
module dc_data_store #(
    parameter int SETS   = 8,
    parameter int LINE_W = 32,
    parameter int IDX_W  = $clog2(SETS)
) (
    input  logic                   clk,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [1:0][LINE_W-1:0] rd_line,
    input  logic                   wr_en,
    input  logic                   wr_way,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [LINE_W-1:0]      wr_line
);

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [LINE_W-1:0] line_q [SETS];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_way == 1'(w))) begin
                line_q[wr_idx] <= wr_line;
            end
        end

        assign rd_line[w] = line_q[rd_idx];
    end

endmodule

// File: rtl/dc_ctrl.sv
module dc_ctrl
    import dc_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int IDX_W  = 3,
    parameter int OFF_W  = 2,
    parameter int TAG_W  = ADDR_W - IDX_W - OFF_W,
    parameter int LINE_W = 8 * (1 << OFF_W)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [OFF_W-1:0]       req_size,
    input  logic [LINE_W-1:0]      req_wdata,
    output logic                   busy,
    output logic                   resp_valid,
    output logic                   resp_hit,
    output logic                   resp_err,
    output logic [LINE_W-1:0]      resp_rdata,
    output logic                   mem_req_valid,
    input  logic                   mem_req_ready,
    output logic                   mem_req_write,
    output logic [TAG_W+IDX_W-1:0] mem_req_addr,
    output logic [LINE_W-1:0]      mem_req_wdata,
    input  logic                   mem_rsp_valid,
    input  logic [LINE_W-1:0]      mem_rsp_data,
    output logic [IDX_W-1:0]       ts_rd_idx,
    input  logic [1:0][TAG_W-1:0]  ts_tag,
    input  logic [1:0]             ts_valid,
    input  logic [1:0]             ts_dirty,
    input  logic                   ts_lru,
    output logic                   ts_wr_en,
    output logic                   ts_wr_way,
    output logic [IDX_W-1:0]       ts_wr_idx,
    output logic [TAG_W-1:0]       ts_wr_tag,
    output logic                   ts_wr_dirty,
    output logic                   ts_lru_en,
    output logic [IDX_W-1:0]       ts_lru_idx,
    output logic                   ts_lru_used,
    input  logic [1:0][LINE_W-1:0] ds_line,
    output logic                   ds_wr_en,
    output logic                   ds_wr_way,
    output logic [IDX_W-1:0]       ds_wr_idx,
    output logic [LINE_W-1:0]      ds_wr_line
);

    localparam int LINE_BYTES = 1 << OFF_W;

    function automatic logic [LINE_W-1:0] pick_bytes(input logic [LINE_W-1:0] line,
                                                     input logic [OFF_W-1:0]  off,
                                                     input logic [OFF_W-1:0]  sz);
        logic [LINE_W-1:0] r;
        r = '0;
        for (int i = 0; i < LINE_BYTES; i++) begin
            if ((i <= int'(sz)) && (int'(off) + i < LINE_BYTES)) begin
                r[i*8 +: 8] = line[(int'(off) + i)*8 +: 8];
            end
        end
        return r;
    endfunction

    function automatic logic [LINE_W-1:0] merge_bytes(input logic [LINE_W-1:0] line,
                                                      input logic [LINE_W-1:0] wd,
                                                      input logic [OFF_W-1:0]  off,
                                                      input logic [OFF_W-1:0]  sz);
        logic [LINE_W-1:0] r;
        r = line;
        for (int j = 0; j < LINE_BYTES; j++) begin
            if ((j >= int'(off)) && (j - int'(off) <= int'(sz))) begin
                r[j*8 +: 8] = wd[(j - int'(off))*8 +: 8];
            end
        end
        return r;
    endfunction

    dc_state_e st_q, st_d;

    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [OFF_W-1:0]  req_off;
    logic              req_err;
    logic [1:0]        way_hit;
    logic              hit_any;
    logic              hit_way;
    logic              vic_way;
    logic              accept;

    logic              q_write;
    logic [TAG_W-1:0]  q_tag;
    logic [IDX_W-1:0]  q_idx;
    logic [OFF_W-1:0]  q_off;
    logic [OFF_W-1:0]  q_size;
    logic [LINE_W-1:0] q_wdata;
    logic              q_way;
    logic [TAG_W-1:0]  q_vtag;

    logic              rv_d, rh_d, re_d;
    logic [LINE_W-1:0] rd_d;

    assign req_tag = req_addr[ADDR_W-1 -: TAG_W];
    assign req_idx = req_addr[OFF_W +: IDX_W];
    assign req_off = req_addr[OFF_W-1:0];
    assign req_err = (int'(req_off) + int'(req_size)) >= LINE_BYTES;
    assign accept  = (st_q == ST_IDLE) && req_valid;

    assign ts_rd_idx = (st_q == ST_IDLE) ? req_idx : q_idx;

    always_comb begin
        for (int w = 0; w < 2; w++) begin
            way_hit[w] = ts_valid[w] && (ts_tag[w] == req_tag);
        end
        hit_any = |way_hit;
        hit_way = way_hit[1];
        if (!ts_valid[0]) begin
            vic_way = 1'b0;
        end else if (!ts_valid[1]) begin
            vic_way = 1'b1;
        end else begin
            vic_way = ts_lru;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (accept && !req_err && !hit_any) begin
                    st_d = (ts_valid[vic_way] && ts_dirty[vic_way]) ? ST_EVICT : ST_FETCH;
                end
            end
            ST_EVICT: if (mem_req_ready) st_d = ST_FETCH;
            ST_FETCH: if (mem_req_ready) st_d = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // outputs of the state machine
    always_comb begin
        busy          = (st_q != ST_IDLE);
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = {q_tag, q_idx};
        mem_req_wdata = ds_line[q_way];
        ts_wr_en      = 1'b0;
        ts_wr_way     = hit_way;
        ts_wr_idx     = req_idx;
        ts_wr_tag     = req_tag;
        ts_wr_dirty   = 1'b1;
        ts_lru_en     = 1'b0;
        ts_lru_idx    = req_idx;
        ts_lru_used   = hit_way;
        ds_wr_en      = 1'b0;
        ds_wr_way     = hit_way;
        ds_wr_idx     = req_idx;
        ds_wr_line    = merge_bytes(ds_line[hit_way], req_wdata, req_off, req_size);
        rv_d          = 1'b0;
        rh_d          = 1'b0;
        re_d          = 1'b0;
        rd_d          = '0;
        unique case (st_q)
            ST_IDLE: begin
                if (accept) begin
                    if (req_err) begin
                        rv_d = 1'b1;
                        re_d = 1'b1;
                    end else if (hit_any) begin
                        rv_d      = 1'b1;
                        rh_d      = 1'b1;
                        ts_lru_en = 1'b1;
                        if (req_write) begin
                            ts_wr_en = 1'b1;
                            ds_wr_en = 1'b1;
                        end else begin
                            rd_d = pick_bytes(ds_line[hit_way], req_off, req_size);
                        end
                    end
                end
            end
            ST_EVICT: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = {q_vtag, q_idx};
            end
            ST_FETCH: begin
                mem_req_valid = 1'b1;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    rv_d        = 1'b1;
                    ts_wr_en    = 1'b1;
                    ts_wr_way   = q_way;
                    ts_wr_idx   = q_idx;
                    ts_wr_tag   = q_tag;
                    ts_wr_dirty = q_write;
                    ts_lru_en   = 1'b1;
                    ts_lru_idx  = q_idx;
                    ts_lru_used = q_way;
                    ds_wr_en    = 1'b1;
                    ds_wr_way   = q_way;
                    ds_wr_idx   = q_idx;
                    if (q_write) begin
                        ds_wr_line = merge_bytes(mem_rsp_data, q_wdata, q_off, q_size);
                    end else begin
                        ds_wr_line = mem_rsp_data;
                        rd_d       = pick_bytes(mem_rsp_data, q_off, q_size);
                    end
                end
            end
            default: ;
        endcase
    end

    // miss capture
    always_ff @(posedge clk) begin
        if (accept && !req_err && !hit_any) begin
            q_write <= req_write;
            q_tag   <= req_tag;
            q_idx   <= req_idx;
            q_off   <= req_off;
            q_size  <= req_size;
            q_wdata <= req_wdata;
            q_way   <= vic_way;
            q_vtag  <= ts_tag[vic_way];
        end
    end

    // response register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_err   <= 1'b0;
            resp_rdata <= '0;
        end else begin
            resp_valid <= rv_d;
            resp_hit   <= rh_d;
            resp_err   <= re_d;
            resp_rdata <= rd_d;
        end
    end

    AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_err && hit_any) |=> (resp_valid && resp_hit && !busy)); // R4
    AST_RESP_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !(resp_hit && resp_err)); // R4
    AST_BUSY_ENDS_WITH_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (resp_valid && !resp_hit && !resp_err)); // R5
    AST_WB_BEFORE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write && mem_req_ready) |=>
            (mem_req_valid && !mem_req_write &&
             mem_req_addr[IDX_W-1:0] == $past(mem_req_addr[IDX_W-1:0]))); // R7
    AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) &&
             $stable(mem_req_wdata))); // R7
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_err) |-> (!busy && !mem_req_valid)); // R9

endmodule

// File: rtl/dcache2w.sv
module dcache2w #(
    parameter int ADDR_W = 7,
    parameter int IDX_W  = 3,
    parameter int OFF_W  = 2,
    parameter int TAG_W  = ADDR_W - IDX_W - OFF_W,
    parameter int LINE_W = 8 * (1 << OFF_W),
    parameter int SETS   = 1 << IDX_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [OFF_W-1:0]       req_size,
    input  logic [LINE_W-1:0]      req_wdata,
    output logic                   busy,
    output logic                   resp_valid,
    output logic                   resp_hit,
    output logic                   resp_err,
    output logic [LINE_W-1:0]      resp_rdata,
    output logic                   mem_req_valid,
    input  logic                   mem_req_ready,
    output logic                   mem_req_write,
    output logic [TAG_W+IDX_W-1:0] mem_req_addr,
    output logic [LINE_W-1:0]      mem_req_wdata,
    input  logic                   mem_rsp_valid,
    input  logic [LINE_W-1:0]      mem_rsp_data
);

    logic [IDX_W-1:0]       rd_idx;
    logic [1:0][TAG_W-1:0]  ts_tag;
    logic [1:0]             ts_valid;
    logic [1:0]             ts_dirty;
    logic                   ts_lru;
    logic                   ts_wr_en, ts_wr_way, ts_wr_dirty;
    logic [IDX_W-1:0]       ts_wr_idx;
    logic [TAG_W-1:0]       ts_wr_tag;
    logic                   ts_lru_en, ts_lru_used;
    logic [IDX_W-1:0]       ts_lru_idx;
    logic [1:0][LINE_W-1:0] ds_line;
    logic                   ds_wr_en, ds_wr_way;
    logic [IDX_W-1:0]       ds_wr_idx;
    logic [LINE_W-1:0]      ds_wr_line;

    dc_tag_store #(.SETS(SETS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (rd_idx),
        .rd_tag   (ts_tag),
        .rd_valid (ts_valid),
        .rd_dirty (ts_dirty),
        .rd_lru   (ts_lru),
        .wr_en    (ts_wr_en),
        .wr_way   (ts_wr_way),
        .wr_idx   (ts_wr_idx),
        .wr_tag   (ts_wr_tag),
        .wr_dirty (ts_wr_dirty),
        .lru_en   (ts_lru_en),
        .lru_idx  (ts_lru_idx),
        .lru_used (ts_lru_used)
    );

    dc_data_store #(.SETS(SETS), .LINE_W(LINE_W), .IDX_W(IDX_W)) u_data (
        .clk     (clk),
        .rd_idx  (rd_idx),
        .rd_line (ds_line),
        .wr_en   (ds_wr_en),
        .wr_way  (ds_wr_way),
        .wr_idx  (ds_wr_idx),
        .wr_line (ds_wr_line)
    );

    dc_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .TAG_W(TAG_W),
              .LINE_W(LINE_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .req_size      (req_size),
        .req_wdata     (req_wdata),
        .busy          (busy),
        .resp_valid    (resp_valid),
        .resp_hit      (resp_hit),
        .resp_err      (resp_err),
        .resp_rdata    (resp_rdata),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .ts_rd_idx     (rd_idx),
        .ts_tag        (ts_tag),
        .ts_valid      (ts_valid),
        .ts_dirty      (ts_dirty),
        .ts_lru        (ts_lru),
        .ts_wr_en      (ts_wr_en),
        .ts_wr_way     (ts_wr_way),
        .ts_wr_idx     (ts_wr_idx),
        .ts_wr_tag     (ts_wr_tag),
        .ts_wr_dirty   (ts_wr_dirty),
        .ts_lru_en     (ts_lru_en),
        .ts_lru_idx    (ts_lru_idx),
        .ts_lru_used   (ts_lru_used),
        .ds_line       (ds_line),
        .ds_wr_en      (ds_wr_en),
        .ds_wr_way     (ds_wr_way),
        .ds_wr_idx     (ds_wr_idx),
        .ds_wr_line    (ds_wr_line)
    );

endmodule

// File: tb/sim_dcache2w.sv
`timescale 1ns/1ps
module sim_dcache2w;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [6:0]  req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        busy, resp_valid, resp_hit, resp_err;
    logic [31:0] resp_rdata;
    logic        mem_req_valid, mem_req_write;
    logic        mem_req_ready;
    logic [4:0]  mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;

    always #10 clk = ~clk;

    dcache2w u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .busy(busy), .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_err(resp_err),
        .resp_rdata(resp_rdata), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    // memory model
    logic [31:0] bmem [32];
    logic        rdy_q;
    logic        pend;
    logic [4:0]  paddr;
    int          dly;
    int          wb_cnt, fill_cnt;
    logic [4:0]  last_faddr, last_waddr;

    assign mem_req_ready = rdy_q;

    always @(posedge clk) begin
        if (!rst_n) begin
            rdy_q         <= 1'b0;
            pend          <= 1'b0;
            dly           <= 0;
            mem_rsp_valid <= 1'b0;
            mem_rsp_data  <= '0;
        end else begin
            rdy_q         <= ~rdy_q;
            mem_rsp_valid <= 1'b0;
            if (mem_req_valid && rdy_q) begin
                if (mem_req_write) begin
                    bmem[mem_req_addr] <= mem_req_wdata;
                    wb_cnt     <= wb_cnt + 1;
                    last_waddr <= mem_req_addr;
                end else begin
                    pend       <= 1'b1;
                    paddr      <= mem_req_addr;
                    dly        <= 2;
                    fill_cnt   <= fill_cnt + 1;
                    last_faddr <= mem_req_addr;
                end
            end
            if (pend) begin
                if (dly == 0) begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_data  <= bmem[paddr];
                    pend          <= 1'b0;
                end else begin
                    dly <= dly - 1;
                end
            end
        end
    end

    // reference model
    logic [7:0] gm [128];
    logic [1:0] mt [8][2];
    logic       mv [8][2];
    logic       md [8][2];
    logic       ml [8];
    int         exp_wb, exp_fill;
    int         checks = 0;
    int         failures = 0;
    int         cyc = 0;
    logic [31:0] seed = 32'h1234_5678;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            failures++;
            finish_up();
        end
    end

    task automatic clear_model();
        for (int s = 0; s < 8; s++) begin
            ml[s] = 1'b0;
            for (int w = 0; w < 2; w++) begin
                mv[s][w] = 1'b0;
                md[s][w] = 1'b0;
                mt[s][w] = '0;
            end
        end
        for (int a = 0; a < 128; a++) gm[a] = bmem[a/4][(a%4)*8 +: 8];
    endtask

    task automatic do_reset();
        rst_n     = 1'b0;
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        wb_cnt   = 0;
        fill_cnt = 0;
        exp_wb   = 0;
        exp_fill = 0;
        rst_n    = 1'b1;
        clear_model();
        @(negedge clk);
        // R10: quiet outputs after reset
        chk(!busy && !resp_valid && !mem_req_valid, "R10", {busy, resp_valid, mem_req_valid}, 0);
    endtask

    // one access; noisy=1 presents a junk write while busy (R11)
    task automatic acc(input bit wr, input logic [6:0] a, input logic [1:0] sz,
                       input logic [31:0] wd, input bit noisy);
        logic [1:0] tg;
        logic [2:0] ix;
        int         off, n, hw, vw, waited;
        bit         ehit, eerr;
        logic [31:0] erd;
        tg = a[6:5]; ix = a[4:2]; off = int'(a[1:0]); n = int'(sz) + 1;
        eerr = (off + n) > 4;
        hw = -1;
        if (!eerr) begin
            for (int w = 0; w < 2; w++) if (mv[ix][w] && mt[ix][w] == tg) hw = w;
        end
        ehit = (hw >= 0);
        erd = '0;
        if (!eerr) for (int i = 0; i < n; i++) erd[i*8 +: 8] = gm[int'(a) + i];
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
        @(negedge clk);
        if (eerr) begin
            req_valid = 1'b0;
            chk(resp_valid && resp_err && !busy, "R9", {resp_valid, resp_err, busy}, 3'b110);
            chk(wb_cnt == exp_wb && fill_cnt == exp_fill && !mem_req_valid, "R9",
                wb_cnt + fill_cnt, exp_wb + exp_fill);
            return;
        end
        if (ehit) begin
            req_valid = 1'b0;
            chk(resp_valid && resp_hit && !busy && !resp_err, "R4",
                {resp_valid, resp_hit, busy, resp_err}, 4'b1100);
            ml[ix] = ~1'(hw);
            if (wr) md[ix][hw] = 1'b1;
        end else begin
            chk(busy && !resp_valid, "R5", {busy, resp_valid}, 2'b10);
            if (noisy) begin
                req_write = 1'b1; req_addr = a ^ 7'h40; req_size = 2'd3; req_wdata = 32'hDEAD_BEEF;
            end else begin
                req_valid = 1'b0;
            end
            vw = !mv[ix][0] ? 0 : (!mv[ix][1] ? 1 : int'(ml[ix]));
            if (mv[ix][vw] && md[ix][vw]) exp_wb++;
            exp_fill++;
            waited = 0;
            while (!resp_valid && waited < 40) begin
                @(negedge clk);
                waited++;
            end
            req_valid = 1'b0;
            chk(resp_valid && !resp_hit && !busy, "R5", {resp_valid, resp_hit, busy}, 3'b100);
            chk(last_faddr == {tg, ix}, "R1", last_faddr, {tg, ix});
            mv[ix][vw] = 1'b1; mt[ix][vw] = tg; md[ix][vw] = wr; ml[ix] = ~1'(vw);
        end
        if (!wr) chk(resp_rdata == erd, "R2", resp_rdata, erd);
        chk(wb_cnt == exp_wb, "R7", wb_cnt, exp_wb);
        chk(fill_cnt == exp_fill, "R6", fill_cnt, exp_fill);
        if (wr) for (int i = 0; i < n; i++) gm[int'(a) + i] = wd[i*8 +: 8];
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        return s * 32'd1103515245 + 32'd12345;
    endfunction

    initial begin
        for (int i = 0; i < 32; i++)
            for (int j = 0; j < 4; j++) bmem[i][j*8 +: 8] = 8'((i*4 + j) * 37 + 11);
        do_reset();
        // R10: first access misses; R1/R2 address split and byte order
        acc(1'b0, 7'h24, 2'd1, '0, 1'b0);
        acc(1'b0, 7'h24, 2'd1, '0, 1'b0);      // R4 hit
        acc(1'b0, 7'h25, 2'd2, '0, 1'b0);      // R2 three bytes
        // R3/R8 write hit then partial-byte read-back
        acc(1'b1, 7'h25, 2'd1, 32'h0000_A1B2, 1'b0);
        acc(1'b0, 7'h24, 2'd3, '0, 1'b0);
        // R6/R7 set 1 conflicts: fill way1, evict LRU dirty way0
        acc(1'b1, 7'h44, 2'd0, 32'h0000_0077, 1'b0);   // R8 write-allocate
        acc(1'b0, 7'h64, 2'd3, '0, 1'b1);              // R7 dirty victim, R11 noise
        chk(last_waddr == 5'b01001, "R7", last_waddr, 5'b01001);
        acc(1'b0, 7'h24, 2'd3, '0, 1'b0);              // R3 data survived write-back
        acc(1'b0, 7'h04, 2'd3, '0, 1'b1);
        // R9: every line-crossing combination
        for (int o = 0; o < 4; o++)
            for (int s = 0; s < 4; s++)
                if (o + s >= 4) acc(1'b1, 7'(8 + o), 2'(s), 32'hFFFF_FFFF, 1'b0);
        acc(1'b0, 7'h08, 2'd3, '0, 1'b0);              // R9 line unchanged
        // exhaustive byte reads and writes over all addresses
        for (int a = 0; a < 128; a++) acc(1'b0, 7'(a), 2'd0, '0, 1'b0);
        for (int a = 0; a < 128; a++) acc(1'b1, 7'(a), 2'd0, 32'(a * 3 + 1), a[0]);
        // pseudo-random mixed sweep
        for (int k = 0; k < 3000; k++) begin
            logic [1:0] sz;
            logic [1:0] of;
            seed = nxt(seed);
            sz = seed[17:16];
            of = 2'(int'(seed[19:18]) % (4 - int'(sz)));
            acc(seed[20], {seed[25:21], of}, sz, nxt(seed), seed[26] & seed[27]);
        end
        // R10: reset drops all lines
        do_reset();
        acc(1'b0, 7'h24, 2'd3, '0, 1'b0);
        acc(1'b0, 7'h64, 2'd3, '0, 1'b0);
        acc(1'b0, 7'h24, 2'd3, '0, 1'b0);
        finish_up();
    end

endmodule